// File: doc/BRIEF.md
# Processor Status Word Register

This block keeps the status word of a small processor core. Five condition bits (carry, zero, sign, overflow, equal) follow the flags of the arithmetic unit each time an arithmetic or compare operation completes. Two control bits sit beside them: an interrupt enable and a supervisor-mode bit. Conditional jumps read the flags implicitly through a branch-condition selector and a single take/not-take output.

Software may write the whole word directly only while the supervisor bit is set. In user mode such writes are dropped. A strobe from the decoder marks privileged instructions, and the block raises a fault output when one arrives in user mode. On interrupt entry the current word is on `psw_out` for the save sequence, while the register moves to supervisor mode with interrupts masked. On return, a restore strobe reloads the saved word in one cycle.

Top module: `psw_reg`

## Requirements
- R1: After reset the word reads 0x80: supervisor bit set, interrupts disabled, all condition bits 0.
- R2: The layout is: carry bit 0, zero bit 1, sign bit 2, overflow bit 3, equal bit 4, interrupt enable bit 6, supervisor bit 7. When `upd_en` is the winning source, the next word has zero = (alu_result == 0), sign = MSB of alu_result, and carry, overflow and equal copied from alu_carry, alu_ovf and alu_equal. Bits 5 to 7 are kept.
- R3: Bit 5 reads 0 at all times, whatever value is written or restored.
- R4: An explicit write (`wr_en`) while the supervisor bit is 0 is ignored. The word keeps its value unless a flag update, an interrupt entry or a restore happens in the same cycle.
- R5: An explicit write while the supervisor bit is 1 loads wr_data, with bit 5 forced to 0, on the next edge.
- R6: `priv_fault` is 1 exactly when `priv_op` is 1 and the supervisor bit is 0. With the default REGISTER_FAULT=0 this holds in the same cycle.
- R7: `irq_enter` sets the supervisor bit and clears interrupt enable on the next edge, with the condition bits unchanged. During the entry cycle `psw_out` still shows the old word, which is the value to be saved.
- R8: `restore_en` loads restore_word, with bit 5 forced to 0, on the next edge. It wins over an interrupt entry, an explicit write and a flag update in the same cycle.
- R9: `br_take` follows `br_sel` and the current word: 0 always, 1 zero set, 2 zero clear, 3 carry set, 4 sign set, 5 overflow set, 6 equal set, 7 equal clear.
- R10: The source priority for the next word is restore, then interrupt entry, then an accepted supervisor write, then a flag update. A supervisor write in the same cycle as a flag update loads only the written word.
- R11: `int_en` and `sup_mode` always equal bits 6 and 7 of `psw_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_en | input | 1 | An arithmetic or compare operation completed; capture flags |
| alu_result | input | DATA_W | Result of that operation |
| alu_carry | input | 1 | Carry flag from the arithmetic unit |
| alu_ovf | input | 1 | Overflow flag from the arithmetic unit |
| alu_equal | input | 1 | Equal flag from the compare |
| wr_en | input | 1 | Explicit write of the whole word |
| wr_data | input | 8 | Word to write |
| priv_op | input | 1 | A privileged instruction is issuing |
| irq_enter | input | 1 | Interrupt entry strobe |
| restore_en | input | 1 | Interrupt-exit restore strobe |
| restore_word | input | 8 | Saved word to reload |
| br_sel | input | 3 | Branch condition selector |
| psw_out | output | 8 | Current status word |
| int_en | output | 1 | Interrupt enable bit |
| sup_mode | output | 1 | Supervisor bit |
| br_take | output | 1 | Selected branch condition holds |
| priv_fault | output | 1 | Privileged instruction issued in user mode |

## Verification
The properties assume that every strobe and data input carries a known value at each rising edge after reset. They do not assume the strobes are exclusive: any mix of update, write, entry and restore may arrive together, and the properties check each source under the priority order. The stimulus changes inputs only on the falling edge, draws the strobes from a seeded `$urandom` stream at rates that produce frequent collisions, and sends directed sequences that cross between user and supervisor mode. This way both the accepted-write and ignored-write cases are reached.

// File: rtl/psw_pkg.sv
package psw_pkg;

   localparam int PSW_W      = 8;
   localparam int BIT_CARRY  = 0;
   localparam int BIT_ZERO   = 1;
   localparam int BIT_SIGN   = 2;
   localparam int BIT_OVF    = 3;
   localparam int BIT_EQUAL  = 4;
   localparam int BIT_RSV    = 5;
   localparam int BIT_IE     = 6;
   localparam int BIT_SUP    = 7;

   localparam logic [PSW_W-1:0] PSW_RESET     = 8'h80;
   localparam logic [PSW_W-1:0] PSW_LIVE_MASK = 8'hDF;

   typedef struct packed {
      logic sup;
      logic ie;
      logic rsv;
      logic equal;
      logic ovf;
      logic sign;
      logic zero;
      logic carry;
   } psw_t;

   typedef enum logic [2:0] {
      BR_ALWAYS = 3'd0,
      BR_ZERO   = 3'd1,
      BR_NZERO  = 3'd2,
      BR_CARRY  = 3'd3,
      BR_NEG    = 3'd4,
      BR_OVF    = 3'd5,
      BR_EQ     = 3'd6,
      BR_NEQ    = 3'd7
   } br_sel_e;

   typedef enum logic [2:0] {
      SRC_HOLD    = 3'd0,
      SRC_FLAGS   = 3'd1,
      SRC_WRITE   = 3'd2,
      SRC_ENTER   = 3'd3,
      SRC_RESTORE = 3'd4
   } src_e;

endpackage

// File: rtl/psw_flag_capture.sv
module psw_flag_capture
   import psw_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int EQ_FROM_ZERO = 0
) (
   input  logic [DATA_W-1:0] alu_result,
   input  logic              alu_carry,
   input  logic              alu_ovf,
   input  logic              alu_equal,
   input  psw_t              cur,
   output psw_t              nxt
);
   localparam int MSB = DATA_W - 1;

   logic res_zero;
   logic eq_bit;

   assign res_zero = ~|alu_result;

   generate
      if (EQ_FROM_ZERO != 0) begin : g_eq_zero
         assign eq_bit = res_zero;
      end else begin : g_eq_port
         assign eq_bit = alu_equal;
      end
   endgenerate

   always_comb begin
      nxt       = cur;
      nxt.carry = alu_carry;
      nxt.zero  = res_zero;
      nxt.sign  = alu_result[MSB];
      nxt.ovf   = alu_ovf;
      nxt.equal = eq_bit;
      nxt.rsv   = 1'b0;
   end

endmodule

// File: rtl/psw_priv_guard.sv
module psw_priv_guard #(
   parameter int REGISTER_FAULT = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sup,
   input  logic wr_en,
   input  logic priv_op,
   output logic wr_accept,
   output logic priv_fault
);
   logic fault_now;

   assign wr_accept = wr_en & sup;
   assign fault_now = priv_op & ~sup;

   generate
      if (REGISTER_FAULT != 0) begin : g_fault_reg
         logic fault_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) fault_q <= 1'b0;
            else        fault_q <= fault_now;
         end
         assign priv_fault = fault_q;
      end else begin : g_fault_comb
         assign priv_fault = fault_now;
      end
   endgenerate

endmodule

// File: rtl/psw_branch_eval.sv
module psw_branch_eval
   import psw_pkg::*;
(
   input  psw_t       cur,
   input  logic [2:0] br_sel,
   output logic       br_take
);
   always_comb begin
      unique case (br_sel_e'(br_sel))
         BR_ALWAYS: br_take = 1'b1;
         BR_ZERO:   br_take = cur.zero;
         BR_NZERO:  br_take = ~cur.zero;
         BR_CARRY:  br_take = cur.carry;
         BR_NEG:    br_take = cur.sign;
         BR_OVF:    br_take = cur.ovf;
         BR_EQ:     br_take = cur.equal;
         BR_NEQ:    br_take = ~cur.equal;
         default:   br_take = 1'b0;
      endcase
   end

endmodule

// File: rtl/psw_reg.sv
module psw_reg
   import psw_pkg::*;
#(
   parameter int DATA_W         = 16,
   parameter int EQ_FROM_ZERO   = 0,
   parameter int REGISTER_FAULT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_en,
   input  logic [DATA_W-1:0] alu_result,
   input  logic              alu_carry,
   input  logic              alu_ovf,
   input  logic              alu_equal,
   input  logic              wr_en,
   input  logic [7:0]        wr_data,
   input  logic              priv_op,
   input  logic              irq_enter,
   input  logic              restore_en,
   input  logic [7:0]        restore_word,
   input  logic [2:0]        br_sel,
   output logic [7:0]        psw_out,
   output logic              int_en,
   output logic              sup_mode,
   output logic              br_take,
   output logic              priv_fault
);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("psw_reg: DATA_W must be at least 2");
      end
      if (EQ_FROM_ZERO != 0 && EQ_FROM_ZERO != 1) begin : g_bad_eq
         $error("psw_reg: EQ_FROM_ZERO must be 0 or 1");
      end
      if (REGISTER_FAULT != 0 && REGISTER_FAULT != 1) begin : g_bad_fault
         $error("psw_reg: REGISTER_FAULT must be 0 or 1");
      end
   endgenerate

   psw_t psw_q;
   psw_t psw_d;
   psw_t flag_word;
   src_e src;
   logic wr_accept;

   psw_flag_capture #(
      .DATA_W       (DATA_W),
      .EQ_FROM_ZERO (EQ_FROM_ZERO)
   ) u_flags (
      .alu_result (alu_result),
      .alu_carry  (alu_carry),
      .alu_ovf    (alu_ovf),
      .alu_equal  (alu_equal),
      .cur        (psw_q),
      .nxt        (flag_word)
   );

   psw_priv_guard #(
      .REGISTER_FAULT (REGISTER_FAULT)
   ) u_guard (
      .clk        (clk),
      .rst_n      (rst_n),
      .sup        (psw_q.sup),
      .wr_en      (wr_en),
      .priv_op    (priv_op),
      .wr_accept  (wr_accept),
      .priv_fault (priv_fault)
   );

   psw_branch_eval u_branch (
      .cur     (psw_q),
      .br_sel  (br_sel),
      .br_take (br_take)
   );

   // Source priority: restore, entry, accepted write, flag update.
   always_comb begin
      if (restore_en)     src = SRC_RESTORE;
      else if (irq_enter) src = SRC_ENTER;
      else if (wr_accept) src = SRC_WRITE;
      else if (upd_en)    src = SRC_FLAGS;
      else                src = SRC_HOLD;
   end

   always_comb begin
      psw_d = psw_q;
      unique case (src)
         SRC_RESTORE: psw_d = psw_t'(restore_word & PSW_LIVE_MASK);
         SRC_ENTER: begin
            psw_d.sup = 1'b1;
            psw_d.ie  = 1'b0;
         end
         SRC_WRITE:   psw_d = psw_t'(wr_data & PSW_LIVE_MASK);
         SRC_FLAGS:   psw_d = flag_word;
         default:     psw_d = psw_q;
      endcase
      psw_d.rsv = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) psw_q <= psw_t'(PSW_RESET);
      else        psw_q <= psw_d;
   end

   assign psw_out  = psw_q;
   assign int_en   = psw_q.ie;
   assign sup_mode = psw_q.sup;

endmodule

// File: rtl/psw_reg_chk.sv
module psw_reg_chk #(
   parameter int DATA_W         = 16,
   parameter int REGISTER_FAULT = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              upd_en,
   input logic [DATA_W-1:0] alu_result,
   input logic              alu_carry,
   input logic              alu_ovf,
   input logic              alu_equal,
   input logic              wr_en,
   input logic [7:0]        wr_data,
   input logic              priv_op,
   input logic              irq_enter,
   input logic              restore_en,
   input logic [7:0]        restore_word,
   input logic [2:0]        br_sel,
   input logic [7:0]        psw_out,
   input logic              int_en,
   input logic              sup_mode,
   input logic              br_take,
   input logic              priv_fault
);

   logic sup_wr;
   logic flag_win;
   assign sup_wr   = wr_en && sup_mode && !restore_en && !irq_enter;
   assign flag_win = upd_en && !restore_en && !irq_enter && !(wr_en && sup_mode);

   a_r1_reset_word: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> psw_out == 8'h80);

   a_r2_flag_zero_sign: assert property (@(posedge clk) disable iff (!rst_n)
      flag_win |=> (psw_out[1] == ($past(alu_result) == '0)) &&
                   (psw_out[2] == $past(alu_result[DATA_W-1])) &&
                   (psw_out[0] == $past(alu_carry)) &&
                   (psw_out[3] == $past(alu_ovf)) &&
                   (psw_out[7:5] == $past(psw_out[7:5])));

   a_r3_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
      psw_out[5] == 1'b0);

   a_r4_user_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !sup_mode && !upd_en && !restore_en && !irq_enter) |=> $stable(psw_out));

   a_r5_sup_write: assert property (@(posedge clk) disable iff (!rst_n)
      sup_wr |=> psw_out == ($past(wr_data) & 8'hDF));

   generate
      if (REGISTER_FAULT != 0) begin : g_chk_fault_reg
         a_r6_fault_reg: assert property (@(posedge clk) disable iff (!rst_n)
            priv_op |=> priv_fault == !$past(sup_mode));
      end else begin : g_chk_fault_comb
         a_r6_fault_comb: assert property (@(posedge clk) disable iff (!rst_n)
            priv_fault == (priv_op && !sup_mode));
      end
   endgenerate

   a_r7_irq_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_enter && !restore_en) |=> sup_mode && !int_en &&
                                     (psw_out[4:0] == $past(psw_out[4:0])));

   a_r8_restore: assert property (@(posedge clk) disable iff (!rst_n)
      restore_en |=> psw_out == ($past(restore_word) & 8'hDF));

   a_r9_br_always: assert property (@(posedge clk) disable iff (!rst_n)
      (br_sel == 3'd0) |-> br_take);

   a_r9_br_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (br_sel == 3'd1) |-> br_take == psw_out[1]);

   a_r9_br_neq: assert property (@(posedge clk) disable iff (!rst_n)
      (br_sel == 3'd7) |-> br_take == !psw_out[4]);

   a_r10_write_over_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (sup_wr && upd_en) |=> psw_out == ($past(wr_data) & 8'hDF));

   a_r11_ctrl_outputs: assert property (@(posedge clk) disable iff (!rst_n)
      (int_en == psw_out[6]) && (sup_mode == psw_out[7]));

endmodule

bind psw_reg psw_reg_chk #(.DATA_W(DATA_W), .REGISTER_FAULT(REGISTER_FAULT)) u_chk (.*);

// File: tb/psw_reg_tb.sv
`timescale 1ns/1ps
module psw_reg_tb;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          upd_en = 0, alu_carry = 0, alu_ovf = 0, alu_equal = 0;
   logic [DW-1:0] alu_result = '0;
   logic          wr_en = 0, priv_op = 0, irq_enter = 0, restore_en = 0;
   logic [7:0]    wr_data = '0, restore_word = '0;
   logic [2:0]    br_sel = '0;
   logic [7:0]    psw_out;
   logic          int_en, sup_mode, br_take, priv_fault;

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] exp_psw;

   always #2.5 clk = ~clk;

   psw_reg #(.DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .alu_result(alu_result),
      .alu_carry(alu_carry), .alu_ovf(alu_ovf), .alu_equal(alu_equal),
      .wr_en(wr_en), .wr_data(wr_data), .priv_op(priv_op),
      .irq_enter(irq_enter), .restore_en(restore_en), .restore_word(restore_word),
      .br_sel(br_sel), .psw_out(psw_out), .int_en(int_en), .sup_mode(sup_mode),
      .br_take(br_take), .priv_fault(priv_fault)
   );

   function automatic logic [7:0] model_next(logic [7:0] cur);
      logic [7:0] n;
      n = cur;
      if (restore_en)            n = restore_word & 8'hDF;
      else if (irq_enter)        n = (cur | 8'h80) & 8'hBF;
      else if (wr_en && cur[7])  n = wr_data & 8'hDF;
      else if (upd_en)           n = {cur[7:5], alu_equal, alu_ovf,
                                      alu_result[DW-1], (alu_result == '0), alu_carry};
      return n;
   endfunction

   function automatic string model_tag(logic [7:0] cur);
      if (restore_en)                      return "R8";
      else if (irq_enter)                  return "R7";
      else if (wr_en && cur[7] && upd_en)  return "R10";
      else if (wr_en && cur[7])            return "R5";
      else if (upd_en)                     return "R2";
      else if (wr_en)                      return "R4";
      return "R3";
   endfunction

   function automatic logic model_br(logic [7:0] w, logic [2:0] s);
      case (s)
         3'd0: return 1'b1;
         3'd1: return w[1];
         3'd2: return !w[1];
         3'd3: return w[0];
         3'd4: return w[2];
         3'd5: return w[3];
         3'd6: return w[4];
         default: return !w[4];
      endcase
   endfunction

   task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   // Inputs are set at a falling edge; this checks combinational outputs,
   // clocks one edge, and checks the new word at the next falling edge.
   task automatic step();
      string t;
      #1;
      check("R9", {7'd0, br_take}, {7'd0, model_br(exp_psw, br_sel)});
      check("R6", {7'd0, priv_fault}, {7'd0, priv_op && !exp_psw[7]});
      t = model_tag(exp_psw);
      @(posedge clk);
      exp_psw = model_next(exp_psw);
      @(negedge clk);
      check(t, psw_out, exp_psw);
      check("R11", {6'd0, sup_mode, int_en}, {6'd0, exp_psw[7], exp_psw[6]});
   endtask

   task automatic idle();
      upd_en = 0; wr_en = 0; priv_op = 0; irq_enter = 0; restore_en = 0;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(5.0 * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int seed;
      seed = 32'h5eed_1234;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      exp_psw = 8'h80;
      check("R1", psw_out, 8'h80);

      // R5: supervisor write drops to user mode, bit 5 forced low (R3)
      wr_en = 1; wr_data = 8'h61; step(); idle();
      // R4: user write ignored
      wr_en = 1; wr_data = 8'hFF; step(); idle();
      // R6: privileged op in user mode faults
      priv_op = 1; step(); idle();
      // R2: flag update, zero result
      upd_en = 1; alu_result = '0; alu_carry = 1; alu_ovf = 0; alu_equal = 1;
      br_sel = 3'd1; step(); idle();
      // R2: negative result, R9 sign branch
      upd_en = 1; alu_result = 16'h8001; alu_carry = 0; alu_ovf = 1; alu_equal = 0;
      br_sel = 3'd4; step(); idle();
      br_sel = 3'd4; step();
      // R7: entry clears enable, sets supervisor, keeps flags
      irq_enter = 1; upd_en = 1; alu_result = 16'h0; step(); idle();
      // R8: restore beats update, entry and write
      restore_en = 1; restore_word = 8'hFF; irq_enter = 1; wr_en = 1; wr_data = 8'h00;
      upd_en = 1; step(); idle();
      // R10: supervisor write beats flag update
      wr_en = 1; wr_data = 8'h95; upd_en = 1; alu_result = 16'h0; step(); idle();
      priv_op = 1; step(); idle();

      for (int i = 0; i < 600; i++) begin
         upd_en       = ($urandom_range(0, 99) < 45);
         alu_result   = DW'($urandom);
         if ($urandom_range(0, 5) == 0) alu_result = '0;
         alu_carry    = $urandom_range(0, 1);
         alu_ovf      = $urandom_range(0, 1);
         alu_equal    = $urandom_range(0, 1);
         wr_en        = ($urandom_range(0, 99) < 30);
         wr_data      = 8'($urandom);
         priv_op      = ($urandom_range(0, 99) < 30);
         irq_enter    = ($urandom_range(0, 99) < 10);
         restore_en   = ($urandom_range(0, 99) < 10);
         restore_word = 8'($urandom);
         br_sel       = 3'($urandom);
         step();
      end
      idle();
      finish_run();
   end

endmodule